// File: doc/BRIEF.md
# Dual Wiper Register Command Engine

This block sits behind a serial mode-0 link (chip select active low, data taken on the rising clock edge, read data launched on the falling edge) and runs the command set of two digitally stepped wipers. Each wiper owns a 6-bit position register and four 6-bit data registers. A frame opens with an identity byte carrying a fixed type nibble and a two-bit bus address. An instruction byte follows, holding an opcode, a data-register index and a pot select. Some commands add a third byte that carries data in or out.

Commands read or write a wiper position or a data register, copy a data register into a wiper or a wiper into a data register, either for one pot or for both pots at once, report a busy flag, or enter an open-ended stepping mode that nudges the chosen wiper once per clock. Each wiper position is decoded to a one-hot select over its 64 taps. Every change to a data register also raises a one-cycle store request for an external sequencer that owns the nonvolatile timing. That sequencer reports back through a busy input. The serial pins are sampled by the system clock, which must run several times faster than the serial clock.

Top module: `wiper_cmd_engine`

## Requirements
- R1: During and after reset each data register takes its value from `nv_image` (slice `(p*4+r)*6` for pot p, register r) and each wiper position takes the value of its own register 0; `sdo_oe` is low.
- R2: A frame is acted on only if its first byte is `0101 00 A1 A0` (MSB first) with A1:A0 equal to `dev_addr`; any other first byte leaves every register unchanged.
- R3: Opcode 1001 (instruction bits 7:4) returns `00` followed by the selected wiper position, MSB first, on `sdo` during bits 16 to 23; each bit changes after a falling serial clock edge and `sdo_oe` is high only while chip select is low in that third byte of a read command.
- R4: Opcode 1011 returns the data register picked by instruction bits 3:2 of the pot picked by instruction bit 0, in the same third-byte format as R3.
- R5: Opcodes 1010 (write wiper) and 1100 (write data register) take the low six bits of the third byte when chip select rises after exactly 24 clocks. A shorter frame changes nothing. Opcode 1100 raises `store_req` for one cycle, with `store_mask` bit p set for pot p and `store_sel` equal to the register index.
- R6: Opcode 1101 copies the selected data register into the wiper of the selected pot. Opcode 1110 copies the wiper into the data register and raises a store request. Both act when chip select rises after exactly 16 clocks.
- R7: Opcode 0001 loads both wipers from their data register at the shared index. Opcode 1000 stores both wipers into that register and raises one store request with `store_mask` = 11. Both act after exactly 16 clocks.
- R8: After the instruction byte of opcode 0010, each further rising serial clock steps the selected wiper one tap up if `sdi` is 1 and one tap down if it is 0, until chip select rises. The position holds at 63 going up and at 0 going down.
- R9: Opcode 0101 returns `store_busy` in bit 0 of the third byte, with bits 7:1 zero.
- R10: Any opcode outside the ten listed, or an instruction byte with bit 1 set, changes no register and never raises `sdo_oe`.
- R11: `tap0_sel` and `tap1_sel` each have exactly one bit set, at the index equal to that wiper's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| dev_addr | input | 2 | Bus address this instance answers to |
| nv_image | input | 48 | Restored data register contents, loaded at reset |
| store_busy | input | 1 | Nonvolatile store in progress |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| store_req | output | 1 | One-cycle request to persist data registers |
| store_mask | output | 2 | Pots whose register must be persisted |
| store_sel | output | 2 | Data register index to persist |
| tap0_sel | output | 64 | One-hot tap select of wiper 0 |
| tap1_sel | output | 64 | One-hot tap select of wiper 1 |

## Verification
The bench builds the block with its default six-bit wiper width, so there are 64 taps and four data registers per pot. Both saturation ends can be reached with a few step clocks from values written just below 63 and just above 0. The one-hot decode is watched over the whole 64-bit select. The fixed identity and instruction byte layouts let the same frames exercise address mismatch, short frames, reserved opcodes and the 16-clock and 24-clock commit points.

// File: rtl/wcmd_pkg.sv
package wcmd_pkg;
   typedef enum logic [3:0] {
      OP_ALL_DR2WCR = 4'b0001,
      OP_STEP       = 4'b0010,
      OP_STATUS     = 4'b0101,
      OP_ALL_WCR2DR = 4'b1000,
      OP_RD_WCR     = 4'b1001,
      OP_WR_WCR     = 4'b1010,
      OP_RD_DR      = 4'b1011,
      OP_WR_DR      = 4'b1100,
      OP_DR2WCR     = 4'b1101,
      OP_WCR2DR     = 4'b1110
   } op_e;

   localparam logic [3:0] DEV_TYPE = 4'b0101;
   localparam int         BYTE_W   = 8;
   localparam int         SEL_W    = 2;
   localparam int         NUM_DR   = 1 << SEL_W;
   localparam int         NUM_POT  = 2;
   localparam int         CNT_W    = 5;
endpackage

// File: rtl/wcmd_tapdec.sv
module wcmd_tapdec #(
   parameter int WW = 6
) (
   input  logic [WW-1:0]      code,
   output logic [(1<<WW)-1:0] onehot
);
   localparam int TAPS = 1 << WW;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign onehot[t] = (code == WW'(t));
   end
endmodule

// File: rtl/wcmd_frame.sv
module wcmd_frame
   import wcmd_pkg::*;
#(
   parameter int WW = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sck,
   input  logic             sdi,
   input  logic [1:0]       dev_addr,
   output logic             cs_act,
   output logic             sck_rise,
   output logic             sck_fall,
   output logic             cs_end,
   output logic             sdi_s,
   output logic [CNT_W-1:0] cnt,
   output logic             id_ok,
   output logic [3:0]       op,
   output logic [SEL_W-1:0] rsel,
   output logic             pot,
   output logic [WW-1:0]    data
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              cs_r, cs_p, sck_r, sck_p, sdi_r;
   logic [BYTE_W-1:0] sr, sr_next;

   assign cs_act   = ~cs_r;
   assign sck_rise = cs_act & sck_r & ~sck_p;
   assign sck_fall = cs_act & ~sck_r & sck_p;
   assign cs_end   = cs_r & ~cs_p;
   assign sdi_s    = sdi_r;
   assign sr_next  = {sr[BYTE_W-2:0], sdi_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_r  <= 1'b1;
         cs_p  <= 1'b1;
         sck_r <= 1'b0;
         sck_p <= 1'b0;
         sdi_r <= 1'b0;
      end else begin
         cs_r  <= cs_n;
         cs_p  <= cs_r;
         sck_r <= sck;
         sck_p <= sck_r;
         sdi_r <= sdi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         cnt   <= '0;
         id_ok <= 1'b0;
         op    <= '0;
         rsel  <= '0;
         pot   <= 1'b0;
         data  <= '0;
      end else if (!cs_act) begin
         cnt   <= '0;
         id_ok <= 1'b0;
      end else if (sck_rise) begin
         sr  <= sr_next;
         cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
         if (cnt == CNT_W'(7))
            id_ok <= (sr_next == {DEV_TYPE, 2'b00, dev_addr});
         if (cnt == CNT_W'(15)) begin
            // a set reserved bit turns the opcode into one that is ignored
            op   <= sr_next[1] ? 4'b0000 : sr_next[7:4];
            rsel <= sr_next[3:2];
            pot  <= sr_next[0];
         end
         if (cnt == CNT_W'(23))
            data <= sr_next[WW-1:0];
      end
   end
endmodule

// File: rtl/wcmd_regs.sv
module wcmd_regs
   import wcmd_pkg::*;
#(
   parameter int WW = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_POT*NUM_DR*WW-1:0] nv_image,
   input  logic                         store_busy,
   input  logic                         cs_act,
   input  logic                         sck_rise,
   input  logic                         sck_fall,
   input  logic                         cs_end,
   input  logic                         sdi_s,
   input  logic [CNT_W-1:0]             cnt,
   input  logic                         id_ok,
   input  logic [3:0]                   op,
   input  logic [SEL_W-1:0]             rsel,
   input  logic                         pot,
   input  logic [WW-1:0]                data,
   output logic [NUM_POT*WW-1:0]        wcr_flat,
   output logic                         sdo,
   output logic                         sdo_oe,
   output logic                         store_req,
   output logic [NUM_POT-1:0]           store_mask,
   output logic [SEL_W-1:0]             store_sel,
   output logic                         step_en
);
   localparam logic [WW-1:0] WMAX = '1;

   logic [WW-1:0]     dr  [NUM_POT][NUM_DR];
   logic [WW-1:0]     wcr [NUM_POT];
   logic [BYTE_W-1:0] rd_val;
   logic              is_read, commit3, commit2;

   for (genvar p = 0; p < NUM_POT; p++) begin : g_flat
      assign wcr_flat[p*WW +: WW] = wcr[p];
   end

   assign is_read = id_ok & ((op == OP_RD_WCR) | (op == OP_RD_DR) | (op == OP_STATUS));
   assign sdo_oe  = is_read & cs_act & (cnt >= CNT_W'(16));
   assign commit3 = cs_end & id_ok & (cnt == CNT_W'(24));
   assign commit2 = cs_end & id_ok & (cnt == CNT_W'(16));
   assign step_en = sck_rise & id_ok & (op == OP_STEP) & (cnt >= CNT_W'(16));

   always_comb begin
      case (op)
         OP_RD_WCR: rd_val = {{(BYTE_W-WW){1'b0}}, wcr[pot]};
         OP_RD_DR:  rd_val = {{(BYTE_W-WW){1'b0}}, dr[pot][rsel]};
         OP_STATUS: rd_val = {{(BYTE_W-1){1'b0}}, store_busy};
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_POT; p++) begin
            for (int r = 0; r < NUM_DR; r++)
               dr[p][r] <= nv_image[(p*NUM_DR+r)*WW +: WW];
            wcr[p] <= nv_image[(p*NUM_DR)*WW +: WW];
         end
         sdo        <= 1'b0;
         store_req  <= 1'b0;
         store_mask <= '0;
         store_sel  <= '0;
      end else begin
         store_req <= 1'b0;
         if (commit3) begin
            case (op)
               OP_WR_WCR: wcr[pot] <= data;
               OP_WR_DR: begin
                  dr[pot][rsel] <= data;
                  store_req     <= 1'b1;
                  store_mask    <= pot ? 2'b10 : 2'b01;
                  store_sel     <= rsel;
               end
               default: ;
            endcase
         end
         if (commit2) begin
            case (op)
               OP_DR2WCR: wcr[pot] <= dr[pot][rsel];
               OP_WCR2DR: begin
                  dr[pot][rsel] <= wcr[pot];
                  store_req     <= 1'b1;
                  store_mask    <= pot ? 2'b10 : 2'b01;
                  store_sel     <= rsel;
               end
               OP_ALL_DR2WCR: begin
                  for (int p = 0; p < NUM_POT; p++)
                     wcr[p] <= dr[p][rsel];
               end
               OP_ALL_WCR2DR: begin
                  for (int p = 0; p < NUM_POT; p++)
                     dr[p][rsel] <= wcr[p];
                  store_req  <= 1'b1;
                  store_mask <= '1;
                  store_sel  <= rsel;
               end
               default: ;
            endcase
         end
         if (step_en) begin
            if (sdi_s && wcr[pot] != WMAX)
               wcr[pot] <= wcr[pot] + 1'b1;
            else if (!sdi_s && wcr[pot] != '0)
               wcr[pot] <= wcr[pot] - 1'b1;
         end
         if (sck_fall && cnt >= CNT_W'(16) && cnt <= CNT_W'(23))
            sdo <= rd_val[3'(CNT_W'(23) - cnt)];
      end
   end
endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
   import wcmd_pkg::*;
#(
   parameter int WW = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sck,
   input  logic                     sdi,
   input  logic [1:0]               dev_addr,
   input  logic [2*4*WW-1:0]        nv_image,
   input  logic                     store_busy,
   output logic                     sdo,
   output logic                     sdo_oe,
   output logic                     store_req,
   output logic [1:0]               store_mask,
   output logic [1:0]               store_sel,
   output logic [(1<<WW)-1:0]       tap0_sel,
   output logic [(1<<WW)-1:0]       tap1_sel
);
   if (WW < 1 || WW > BYTE_W - 2) begin : g_bad_ww
      $error("wiper width must fit the six data bits of a frame");
   end
   if (NUM_POT != 2 || NUM_DR != 4) begin : g_bad_org
      $error("instruction byte addresses exactly two pots of four registers");
   end

   logic             cs_act, sck_rise, sck_fall, cs_end, sdi_s, id_ok, pot, step_en;
   logic [CNT_W-1:0] cnt;
   logic [3:0]       op;
   logic [SEL_W-1:0] rsel;
   logic [WW-1:0]    data;
   logic [2*WW-1:0]  wcr_flat;

   wcmd_frame #(.WW(WW)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .dev_addr(dev_addr), .cs_act(cs_act), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .cs_end(cs_end), .sdi_s(sdi_s), .cnt(cnt),
      .id_ok(id_ok), .op(op), .rsel(rsel), .pot(pot), .data(data)
   );

   wcmd_regs #(.WW(WW)) u_regs (
      .clk(clk), .rst_n(rst_n), .nv_image(nv_image), .store_busy(store_busy),
      .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_end(cs_end), .sdi_s(sdi_s), .cnt(cnt), .id_ok(id_ok), .op(op),
      .rsel(rsel), .pot(pot), .data(data), .wcr_flat(wcr_flat), .sdo(sdo),
      .sdo_oe(sdo_oe), .store_req(store_req), .store_mask(store_mask),
      .store_sel(store_sel), .step_en(step_en)
   );

   wcmd_tapdec #(.WW(WW)) u_dec0 (.code(wcr_flat[WW-1:0]),    .onehot(tap0_sel));
   wcmd_tapdec #(.WW(WW)) u_dec1 (.code(wcr_flat[2*WW-1:WW]), .onehot(tap1_sel));
endmodule

// File: rtl/wiper_cmd_engine_chk.sv
module wiper_cmd_engine_chk #(
   parameter int WW = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                sdo_oe,
   input logic                store_req,
   input logic                cs_end,
   input logic                step_en,
   input logic                sdi_s,
   input logic                pot,
   input logic [2*WW-1:0]     wcr_flat,
   input logic [(1<<WW)-1:0]  tap0_sel,
   input logic [(1<<WW)-1:0]  tap1_sel
);
   localparam logic [WW-1:0] WMAX = '1;

   logic [WW-1:0] w0, w1;
   assign w0 = wcr_flat[WW-1:0];
   assign w1 = wcr_flat[2*WW-1:WW];

   a_r11_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap0_sel) == 1);
   a_r11_onehot1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap1_sel) == 1);
   a_r3_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !$past(cs_n));
   a_r5_store_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> $past(cs_end));
   a_r8_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && sdi_s && !pot && w0 != WMAX) |=> (w0 == $past(w0) + WW'(1)));
   a_r8_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && sdi_s && !pot && w0 == WMAX) |=> (w0 == WMAX));
   a_r8_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !sdi_s && pot && w1 == '0) |=> (w1 == '0));
endmodule

bind wiper_cmd_engine wiper_cmd_engine_chk #(.WW(WW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
   .store_req(store_req), .cs_end(cs_end), .step_en(step_en),
   .sdi_s(sdi_s), .pot(pot), .wcr_flat(wcr_flat),
   .tap0_sel(tap0_sel), .tap1_sel(tap1_sel)
);

// File: tb/wiper_cmd_engine_tb.sv
module wiper_cmd_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 4;
   localparam int WW = 6;
   localparam int NV = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, store_busy = 1'b0;
   logic [1:0] dev_addr = 2'b10;
   logic [47:0] nv_image;
   logic sdo, sdo_oe, store_req;
   logic [1:0] store_mask, store_sel;
   logic [63:0] tap0_sel, tap1_sel;

   int checks = 0;
   int errors = 0;
   int store_cnt = 0;
   logic [1:0] last_mask = '0, last_sel = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wiper_cmd_engine #(.WW(WW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .dev_addr(dev_addr), .nv_image(nv_image), .store_busy(store_busy),
      .sdo(sdo), .sdo_oe(sdo_oe), .store_req(store_req),
      .store_mask(store_mask), .store_sel(store_sel),
      .tap0_sel(tap0_sel), .tap1_sel(tap1_sel)
   );

   always @(posedge clk) begin
      if (store_req) begin
         store_cnt <= store_cnt + 1;
         last_mask <= store_mask;
         last_sel  <= store_sel;
      end
   end

   // entry: {frame[23:0], nbits[5:0], kind[1:0], expect[5:0], req[3:0]}
   // kind 0 none, 1 read byte, 2 wiper 0 tap, 3 wiper 1 tap
   localparam logic [41:0] VEC [NV] = '{
      {24'h529000, 6'd24, 2'd1, 6'd10, 4'd3},  // R3 read wiper 0
      {24'h52B800, 6'd24, 2'd1, 6'd30, 4'd4},  // R4 pot0 reg2
      {24'h52BD00, 6'd24, 2'd1, 6'd63, 4'd4},  // R4 pot1 reg3
      {24'h52A121, 6'd24, 2'd3, 6'd33, 4'd5},  // R5 write wiper 1
      {24'h52C507, 6'd24, 2'd0, 6'd0,  4'd5},  // R5 write pot1 reg1
      {24'h52B500, 6'd24, 2'd1, 6'd7,  4'd5},  // R5 read it back
      {24'h52DC00, 6'd16, 2'd2, 6'd40, 4'd6},  // R6 reg3 to wiper 0
      {24'h52E900, 6'd16, 2'd0, 6'd0,  4'd6},  // R6 wiper 1 to reg2
      {24'h52B900, 6'd24, 2'd1, 6'd33, 4'd6},  // R6 read reg2 of pot1
      {24'h521400, 6'd16, 2'd2, 6'd20, 4'd7},  // R7 global load from reg1
      {24'h529100, 6'd24, 2'd1, 6'd7,  4'd7},  // R7 wiper 1 also loaded
      {24'h528000, 6'd16, 2'd0, 6'd0,  4'd7},  // R7 global store to reg0
      {24'h52B000, 6'd24, 2'd1, 6'd20, 4'd7},  // R7 pot0 reg0
      {24'h52B100, 6'd24, 2'd1, 6'd7,  4'd7},  // R7 pot1 reg0
      {24'h525100, 6'd24, 2'd1, 6'd0,  4'd9},  // R9 status idle
      {24'h51A005, 6'd24, 2'd2, 6'd20, 4'd2},  // R2 other address ignored
      {24'h52A005, 6'd20, 2'd2, 6'd20, 4'd5}   // R5 short frame ignored
   };

   task automatic chk(input int req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tap_of(input logic [63:0] v);
      if ($countones(v) != 1) return -1;
      for (int t = 0; t < 64; t++) if (v[t]) return t;
      return -1;
   endfunction

   task automatic send(input logic [39:0] bits, input int n,
                       output logic [7:0] rd, output bit oe_seen);
      rd = '0;
      oe_seen = 1'b0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         sdi = bits[39-i];
         repeat (HALF) @(negedge clk);
         if (sdo_oe) oe_seen = 1'b1;
         if (i >= 16 && i < 24) rd[23-i] = sdo;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4*HALF) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      bit oe;
      int s0;
      // pot0 regs 10,20,30,40; pot1 regs 50,1,2,63
      nv_image = {6'd63, 6'd2, 6'd1, 6'd50, 6'd40, 6'd30, 6'd20, 6'd10};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk(1, tap_of(tap0_sel), 10);
      chk(1, tap_of(tap1_sel), 50);
      chk(1, int'(sdo_oe), 0);

      for (int k = 0; k < NV; k++) begin
         logic [41:0] v;
         v = VEC[k];
         send({v[41:18], 16'h0}, int'(v[17:12]), rd, oe);
         case (v[11:10])
            2'd1: begin
               chk(int'(v[3:0]), int'(rd), int'(v[9:4]));
               chk(int'(v[3:0]), int'(oe), 1);
            end
            2'd2: chk(int'(v[3:0]), tap_of(tap0_sel), int'(v[9:4]));
            2'd3: chk(int'(v[3:0]), tap_of(tap1_sel), int'(v[9:4]));
            default: ;
         endcase
      end
      // R5 R6 R7: three store requests so far, last one global to reg0
      chk(5, store_cnt, 3);
      chk(7, int'(last_mask), 3);
      chk(7, int'(last_sel), 0);

      // R6 single store from wiper 0 (20) into pot0 reg2
      s0 = store_cnt;
      send({24'h52E800, 16'h0}, 16, rd, oe);
      chk(6, store_cnt - s0, 1);
      chk(6, int'(last_mask), 1);
      chk(6, int'(last_sel), 2);
      send({24'h52B800, 16'h0}, 24, rd, oe);
      chk(6, int'(rd), 20);

      // R9 busy flag reported
      store_busy = 1'b1;
      send({24'h525100, 16'h0}, 24, rd, oe);
      chk(9, int'(rd), 1);
      store_busy = 1'b0;

      // R10 unused opcodes and reserved bit: no drive, no change
      send({24'h520000, 16'h0}, 24, rd, oe);
      chk(10, int'(oe), 0);
      send({24'h52F005, 16'h0}, 24, rd, oe);
      chk(10, tap_of(tap0_sel), 20);
      send({24'h529200, 16'h0}, 24, rd, oe);
      chk(10, int'(oe), 0);

      // R8 stepping: 5 up, 3 down from 20
      send({24'h5220F8, 16'h0}, 24, rd, oe);
      chk(8, tap_of(tap0_sel), 22);
      // R8 saturate high: 62 then 4 up
      send({24'h52A03E, 16'h0}, 24, rd, oe);
      send({24'h5220F0, 16'h0}, 20, rd, oe);
      chk(8, tap_of(tap0_sel), 63);
      // R8 saturate low on pot1: 1 then 3 down
      send({24'h52A101, 16'h0}, 24, rd, oe);
      send({24'h522100, 16'h0}, 19, rd, oe);
      chk(8, tap_of(tap1_sel), 0);
      chk(8, tap_of(tap0_sel), 63);
      // R11 tap select one-hot at the wiper position
      chk(11, $countones(tap1_sel), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule